// File: doc/BRIEF.md
# Up-3 / Down-5 Loadable Wrapping Counter

A synchronous counter of parameterised width (9 bits by default). On every rising clock edge it does one of four things, chosen by two direction inputs:
- load a parallel value;
- step up by a fixed increment (3 by default);
- step down by a fixed decrement (5 by default);
- hold.

Arithmetic wraps modulo 2^WIDTH.

Three single-bit flags are registered together with the count:
- a carry flag, raised only on the up step that wraps past the top value;
- a borrow flag, raised only on the down step that wraps below zero;
- a parity flag, the XOR of all bits of the count now on the output.

Inputs are expected to change on the falling clock edge. Every output is registered, so a change on the inputs shows at the outputs after the next rising edge. A synchronous active-low reset gives the count a defined value before the first load.

Top module: `updown_step_counter`

## Requirements
- R1: While `rst_n` is 0 at a rising edge, the count, carry, borrow and parity outputs all become 0, whatever the other inputs are.
- R2: With `step_up`=0 and `step_dn`=0 (load mode), the count takes `load_val` at the rising edge, and carry and borrow become 0.
- R3: With `step_up`=1 and `step_dn`=0 (up mode), the count becomes (count + 3) mod 512. For example, 0x1FD becomes 0x000 and 0x1FF becomes 0x002.
- R4: With `step_up`=0 and `step_dn`=1 (down mode), the count becomes (count − 5) mod 512. For example, 5 becomes 0, 4 becomes 0x1FF and 0 becomes 0x1FB.
- R5: Carry is 1 only after an up step that passes 511 and wraps. After every other step, load, hold or reset, carry is 0.
- R6: Borrow is 1 only after a down step whose result would be negative and so wraps. A down step that lands exactly on 0 gives borrow 0.
- R7: Parity equals the XOR of all 9 bits of the count now on the output: 1 for an odd number of ones (0x1FF gives 1, 0x1FE gives 0).
- R8: With `step_up`=1 and `step_dn`=1 (hold mode), the count keeps its value, carry and borrow become 0, and parity still matches the held count.
- R9: In up, down and hold modes, the value on `load_val` has no effect on any output.
- R10: Carry and borrow are never 1 in the same cycle.
- R11: All outputs are registered. Inputs applied after a falling edge appear at the outputs only after the following rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_val | input | 9 | Parallel value taken in load mode |
| step_up | input | 1 | Direction control; with step_dn selects load/up/down/hold |
| step_dn | input | 1 | Direction control; with step_up selects load/up/down/hold |
| count_q | output | 9 | Registered count |
| carry_q | output | 1 | Registered wrap-on-increment flag |
| borrow_q | output | 1 | Registered wrap-on-decrement flag |
| parity_q | output | 1 | Registered XOR of the count bits |

## Verification
A wrapping step and the parity of the wrapped result land in the same cycle, so one edge must raise a flag and report the parity of a value that has just crossed the boundary. The bench provokes this in two ways:
- it loads 0x1FF and steps up, which must give count 0x002 with carry 1 and parity 1;
- it loads 0 and steps down, which must give 0x1FB with borrow 1 and parity 0.

Landing exactly on a boundary (0x1FD up to 0, 5 down to 0) is checked alongside, so that the flag is judged against the true wrap condition and not against the value zero.

// File: rtl/ctr_pkg.sv
// Package: shared mode encoding for the wrapping step counter.
// Assumes the mode is formed as {step_up, step_dn}.
package ctr_pkg;

    typedef enum logic [1:0] {
        MODE_LOAD = 2'b00,
        MODE_DOWN = 2'b01,
        MODE_UP   = 2'b10,
        MODE_HOLD = 2'b11
    } ctr_mode_e;

endpackage

// File: rtl/ctr_step.sv
// Module: ctr_step
// Computes the next count and the wrap flags for one clock edge.
// Purely combinational. Assumes UP_STEP and DN_STEP are below 2**WIDTH,
// so that one step wraps at most once.
module ctr_step
    import ctr_pkg::*;
#(
    parameter int WIDTH   = 9,
    parameter int UP_STEP = 3,
    parameter int DN_STEP = 5
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] load_val,
    input  ctr_mode_e        mode,
    output logic [WIDTH-1:0] nxt,
    output logic             wrap_up,
    output logic             wrap_dn
);
    localparam int XW = WIDTH + 1;
    localparam logic [XW-1:0] UP_X = XW'(UP_STEP);
    localparam logic [XW-1:0] DN_X = XW'(DN_STEP);

    logic [XW-1:0] sum_x;
    logic [XW-1:0] dif_x;

    // extended add and subtract; the top bit marks a wrap
    assign sum_x = {1'b0, cur} + UP_X;
    assign dif_x = {1'b0, cur} - DN_X;

    // select the next value and flags from the mode
    always_comb begin
        nxt     = cur;
        wrap_up = 1'b0;
        wrap_dn = 1'b0;
        case (mode)
            MODE_LOAD: nxt = load_val;
            MODE_UP: begin
                nxt     = sum_x[WIDTH-1:0];
                wrap_up = sum_x[WIDTH];
            end
            MODE_DOWN: begin
                nxt     = dif_x[WIDTH-1:0];
                wrap_dn = dif_x[WIDTH];
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/ctr_parity.sv
// Module: ctr_parity
// XOR reduction of a WIDTH-bit word. Combinational; the result is 1
// when the word holds an odd number of ones.
module ctr_parity #(
    parameter int WIDTH = 9
) (
    input  logic [WIDTH-1:0] word,
    output logic             odd
);
    // fold every bit into one XOR accumulator
    always_comb begin
        odd = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            odd = odd ^ word[i];
        end
    end
endmodule

// File: rtl/updown_step_counter.sv
// Module: updown_step_counter
// Loadable counter that steps up by UP_STEP or down by DN_STEP modulo
// 2**WIDTH. Carry, borrow and parity are registered with the count.
// Assumes inputs settle away from the rising edge. The synchronous
// reset is active low.
module updown_step_counter
    import ctr_pkg::*;
#(
    parameter int WIDTH   = 9,
    parameter int UP_STEP = 3,
    parameter int DN_STEP = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] load_val,
    input  logic             step_up,
    input  logic             step_dn,
    output logic [WIDTH-1:0] count_q,
    output logic             carry_q,
    output logic             borrow_q,
    output logic             parity_q
);
    localparam logic [WIDTH-1:0] UP_V = WIDTH'(UP_STEP);
    localparam logic [WIDTH-1:0] DN_V = WIDTH'(DN_STEP);

    ctr_mode_e        mode;
    logic [WIDTH-1:0] nxt;
    logic             wrap_up;
    logic             wrap_dn;
    logic             par_nxt;

    // form the mode from the two direction controls
    assign mode = ctr_mode_e'({step_up, step_dn});

    ctr_step #(
        .WIDTH  (WIDTH),
        .UP_STEP(UP_STEP),
        .DN_STEP(DN_STEP)
    ) u_step (
        .cur     (count_q),
        .load_val(load_val),
        .mode    (mode),
        .nxt     (nxt),
        .wrap_up (wrap_up),
        .wrap_dn (wrap_dn)
    );

    ctr_parity #(
        .WIDTH(WIDTH)
    ) u_par (
        .word(nxt),
        .odd (par_nxt)
    );

    // register the count and all flags together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            carry_q  <= 1'b0;
            borrow_q <= 1'b0;
            parity_q <= 1'b0;
        end else begin
            count_q  <= nxt;
            carry_q  <= wrap_up;
            borrow_q <= wrap_dn;
            parity_q <= par_nxt;
        end
    end

    // R10
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(carry_q && borrow_q));

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_up && !step_dn) |=>
            (count_q == $past(load_val) && !carry_q && !borrow_q));

    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && !step_dn) |=> (count_q == WIDTH'($past(count_q) + UP_V)));

    // R4
    dn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_up && step_dn) |=> (count_q == WIDTH'($past(count_q) - DN_V)));

    // R5
    carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && !step_dn) |=> (carry_q == (count_q < $past(count_q))));

    // R6
    borrow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_up && step_dn) |=> (borrow_q == (count_q > $past(count_q))));

    // R8
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && step_dn) |=> ($stable(count_q) && !carry_q && !borrow_q));

    // R7
    parity_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        parity_q == (^count_q));
endmodule

// File: tb/tb_updown_step_counter.sv
// Directed bench for updown_step_counter. Inputs are driven just after
// a falling edge; outputs are sampled at the next falling edge.
module tb_updown_step_counter;
    localparam int W = 9;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] load_val;
    logic         step_up;
    logic         step_dn;
    logic [W-1:0] count_q;
    logic         carry_q;
    logic         borrow_q;
    logic         parity_q;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    updown_step_counter dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_val(load_val),
        .step_up (step_up),
        .step_dn (step_dn),
        .count_q (count_q),
        .carry_q (carry_q),
        .borrow_q(borrow_q),
        .parity_q(parity_q)
    );

    always #10 clk = ~clk;

    function automatic logic odd_ones(input logic [W-1:0] v);
        return ($countones(v) % 2) == 1;
    endfunction

    // compare all outputs against expected values
    task automatic expect_out(input string req, input logic [W-1:0] c,
                              input logic cy, input logic bw);
        logic p;
        p = odd_ones(c);
        total++;
        if (count_q !== c || carry_q !== cy || borrow_q !== bw || parity_q !== p) begin
            bad++;
            $display("FAIL %s: got count=%h c=%b b=%b p=%b, expected count=%h c=%b b=%b p=%b",
                     req, count_q, carry_q, borrow_q, parity_q, c, cy, bw, p);
        end
    endtask

    // apply one input set and wait to the next falling edge
    task automatic cyc(input logic u, input logic d, input logic [W-1:0] v);
        step_up  = u;
        step_dn  = d;
        load_val = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(1'b0, 1'b0, 9'h155);
        cyc(1'b0, 1'b0, 9'h155);
        expect_out("R1 reset clears", 9'h000, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_load();
        cyc(1'b0, 1'b0, 9'h0A5);
        expect_out("R2 load", 9'h0A5, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 9'h1FE);
        expect_out("R2 load even parity", 9'h1FE, 1'b0, 1'b0);
    endtask

    task automatic t_up_wrap();
        cyc(1'b0, 1'b0, 9'h1FC);
        cyc(1'b1, 1'b0, 9'h000);
        expect_out("R3 up no wrap", 9'h1FF, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 9'h000);
        expect_out("R5 up wrap carry", 9'h002, 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 9'h000);
        expect_out("R5 carry drops", 9'h005, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 9'h1FD);
        cyc(1'b1, 1'b0, 9'h000);
        expect_out("R3 1FD to 0 carry", 9'h000, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 9'h1FE);
        cyc(1'b1, 1'b0, 9'h000);
        expect_out("R3 1FE to 1", 9'h001, 1'b1, 1'b0);
    endtask

    task automatic t_down_wrap();
        cyc(1'b0, 1'b0, 9'h005);
        cyc(1'b0, 1'b1, 9'h000);
        expect_out("R6 land on zero no borrow", 9'h000, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 9'h000);
        expect_out("R4 0 to 1FB borrow", 9'h1FB, 1'b0, 1'b1);
        cyc(1'b0, 1'b1, 9'h000);
        expect_out("R6 borrow drops", 9'h1F6, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 9'h004);
        cyc(1'b0, 1'b1, 9'h000);
        expect_out("R4 4 to 1FF", 9'h1FF, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 9'h003);
        cyc(1'b0, 1'b1, 9'h000);
        expect_out("R4 3 to 1FE", 9'h1FE, 1'b0, 1'b1);
    endtask

    task automatic t_hold();
        cyc(1'b0, 1'b0, 9'h1FD);
        cyc(1'b1, 1'b0, 9'h000);
        cyc(1'b1, 1'b1, 9'h000);
        expect_out("R8 hold clears carry", 9'h000, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 9'h0C7);
        cyc(1'b1, 1'b1, 9'h000);
        expect_out("R8 hold keeps", 9'h0C7, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 9'h000);
        expect_out("R8 hold again", 9'h0C7, 1'b0, 1'b0);
    endtask

    task automatic t_ignore_load();
        cyc(1'b0, 1'b0, 9'h010);
        cyc(1'b1, 1'b0, 9'h1AA);
        expect_out("R9 up ignores load_val", 9'h013, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 9'h0FF);
        expect_out("R9 down ignores load_val", 9'h00E, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 9'h123);
        expect_out("R9 hold ignores load_val", 9'h00E, 1'b0, 1'b0);
    endtask

    task automatic t_same_cycle();
        cyc(1'b0, 1'b0, 9'h1FF);
        expect_out("R7 parity of 1FF", 9'h1FF, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 9'h000);
        expect_out("R10 carry with parity", 9'h002, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 9'h000);
        cyc(1'b0, 1'b1, 9'h000);
        expect_out("R10 borrow with parity", 9'h1FB, 1'b0, 1'b1);
    endtask

    task automatic t_registered();
        cyc(1'b0, 1'b0, 9'h040);
        step_up = 1'b1;
        step_dn = 1'b0;
        #2;
        total++;
        if (count_q !== 9'h040) begin
            bad++;
            $display("FAIL R11 output moved before edge: got %h expected %h", count_q, 9'h040);
        end
        @(negedge clk);
        expect_out("R11 change after rising edge", 9'h043, 1'b0, 1'b0);
    endtask

    task automatic t_reset_mid();
        cyc(1'b0, 1'b0, 9'h1FD);
        rst_n = 1'b0;
        cyc(1'b1, 1'b0, 9'h000);
        expect_out("R1 reset over up step", 9'h000, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n    = 1'b0;
        step_up  = 1'b0;
        step_dn  = 1'b0;
        load_val = '0;
        @(negedge clk);
        t_reset();
        t_load();
        t_up_wrap();
        t_down_wrap();
        t_hold();
        t_ignore_load();
        t_same_cycle();
        t_registered();
        t_reset_mid();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule